// File: doc/BRIEF.md
# Dual-Frame Sequence-Decoupling PLL

This block tracks the fundamental of a three-phase grid from one set of phase-voltage samples per strobe. Each strobe runs a Clarke transform, then projects the stationary vector onto two frames that turn in opposite directions at the estimated angle. A cross-decoupling stage takes the filtered estimate of each sequence, rotates it by twice the angle, and removes it from the other frame, so the double-frequency ripple that an unbalanced grid produces cancels out. Four first-order low-pass filters then give clean d/q amplitudes for both sequences.

A proportional-integral loop drives the decoupled positive q-axis value to zero, which puts the positive sequence on the d-axis. The frequency is held as a phase increment per sample. It starts at the nominal value and is clamped to a window of plus or minus ten percent. The angle is an unsigned phase word that wraps at a full turn. The angle and the filtered terms that feed the decoupling stage always come from the previous sample. Sine and cosine come from a quarter-wave table that is computed when the design is elaborated.

Top module: `ddsrf_pll`

## Requirements
- R1: While reset is asserted and on release, `freq_inc` is the nominal increment 21474836 (that is, floor(2^32 * 50 / 10000)), `theta` is 0, all four dq outputs are 0 and `out_vld` is 0.
- R2: `out_vld` is high for exactly one cycle, namely the cycle after each clock edge at which `smp_stb` is sampled high, and it is low otherwise.
- R3: When `smp_stb` is low, `theta`, `freq_inc` and the dq outputs keep their values, whatever the phase inputs do.
- R4: With all three inputs at zero, each strobe advances `theta` by exactly 21474836 (mod 2^32), `freq_inc` stays at 21474836, and the dq outputs stay at 0.
- R5: On every strobe, the new `theta` equals the previous `theta` plus the new `freq_inc`, modulo 2^32.
- R6: `freq_inc` never leaves the range [19327353, 23622319], which is nominal minus and plus nominal/10. An input at 60 Hz drives it to the upper bound, and one at 40 Hz drives it to the lower bound.
- R7: Inputs are signed Q1.15, and phase b lags phase a by 120 degrees. For a balanced 50 Hz positive-sequence input of amplitude P, after 5000 strobes `pos_d` is within 1500 of P, `|pos_q|` is below 1500, the negative-sequence magnitude is below 1500, and `freq_inc` is within 214748 of nominal.
- R8: When a negative sequence of amplitude N (phase b leading phase a by 120 degrees) is added, sqrt(neg_d^2 + neg_q^2) settles to within 1500 of N, and the positive-sequence outputs still meet R7.
- R9: At 48 Hz and 52 Hz, `freq_inc` settles to within 214748 of f * 2^32 / 10000, and `pos_d` settles to within 1500 of P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_stb | input | 1 | One-cycle strobe: the three phase samples are valid |
| ph_a | input | 16 | Phase a voltage, signed Q1.15 per-unit |
| ph_b | input | 16 | Phase b voltage, signed Q1.15 per-unit |
| ph_c | input | 16 | Phase c voltage, signed Q1.15 per-unit |
| out_vld | output | 1 | Pulse one cycle after a strobe: the outputs are updated |
| freq_inc | output | 32 | Estimated frequency as phase increment per sample |
| theta | output | 32 | Positive-sequence angle, full turn = 2^32 |
| pos_d | output | 16 | Filtered positive-sequence d amplitude, Q1.15 |
| pos_q | output | 16 | Filtered positive-sequence q amplitude, Q1.15 |
| neg_d | output | 16 | Filtered negative-sequence d amplitude, Q1.15 |
| neg_q | output | 16 | Filtered negative-sequence q amplitude, Q1.15 |

## Verification
A wrong decoupling sign or a swapped rotation direction does not stop the loop from running. Instead it leaves the sequences mixed, and after a few hundred strobes this shows at the ports as a negative-sequence magnitude that does not match the injected amount, or as a positive d amplitude that ripples away from P. An error in the integrator or in the clamp shows as a frequency estimate that settles off target or never reaches its limit under 60 Hz or 40 Hz drive. An error in the angle accumulator or in the strobe gating shows within one strobe, as a `theta` step that differs from `freq_inc` or as outputs that move while no strobe is present.

// File: rtl/ddsrf_pkg.sv
package ddsrf_pkg;

  // Wide signed work type for all intermediate fixed-point arithmetic
  typedef logic signed [47:0] wide_t;

  // Indices of the four sequence channels
  typedef enum int {CH_DP = 0, CH_QP = 1, CH_DN = 2, CH_QN = 3} chan_e;

  // Saturate x to a signed range of w bits
  function automatic wide_t clamp_s(input wide_t x, input int w);
    wide_t hi;
    wide_t lo;
    hi = (wide_t'(1) <<< (w - 1)) - wide_t'(1);
    lo = -hi - wide_t'(1);
    if (x > hi) return hi;
    else if (x < lo) return lo;
    else return x;
  endfunction

  // Fixed-point product with fb fractional bits dropped
  function automatic wide_t qmul(input wide_t a, input wide_t b, input int fb);
    logic signed [95:0] p;
    p = 96'(a) * 96'(b);
    return wide_t'(p >>> fb);
  endfunction

  // Quarter-wave sine entry k of 2^lb, sampled at bin centres, scaled to dw-bit signed
  function automatic int sin_tab(input int k, input int lb, input int dw);
    longint x, x2, t, s, lim;
    x  = (longint'(2 * k + 1) * 64'sd3373259426) / (longint'(1) <<< (lb + 2));
    x2 = (x * x) >>> 30;
    t  = x;
    s  = x;
    for (int n = 1; n <= 4; n++) begin
      t = -((t * x2) >>> 30) / longint'((2 * n) * (2 * n + 1));
      s = s + t;
    end
    s   = s >>> (31 - dw);
    lim = (longint'(1) <<< (dw - 1)) - 1;
    if (s > lim) s = lim;
    return int'(s);
  endfunction

endpackage

// File: rtl/ddsrf_trig.sv
module ddsrf_trig #(
  parameter int PW = 32,
  parameter int DW = 16,
  parameter int LB = 6
) (
  input  logic [PW-1:0]        phase,
  output logic signed [DW-1:0] sin_o,
  output logic signed [DW-1:0] cos_o
);
  localparam int N = 1 << LB;

  logic signed [DW-1:0] rom [N];
  for (genvar k = 0; k < N; k++) begin : g_rom
    assign rom[k] = DW'(ddsrf_pkg::sin_tab(k, LB, DW));
  end

  logic [1:0]    quad_s, quad_c;
  logic [LB-1:0] idx;
  logic          unused_lsb;
  logic signed [DW-1:0] mag_s, mag_c;

  assign quad_s     = phase[PW-1 -: 2];
  assign quad_c     = quad_s + 2'd1;        // cosine is a quarter turn ahead
  assign idx        = phase[PW-3 -: LB];
  assign unused_lsb = ^phase[PW-3-LB:0];

  always_comb begin
    mag_s = quad_s[0] ? rom[~idx] : rom[idx];
    mag_c = quad_c[0] ? rom[~idx] : rom[idx];
    sin_o = quad_s[1] ? -mag_s : mag_s;
    cos_o = quad_c[1] ? -mag_c : mag_c;
  end
endmodule

// File: rtl/ddsrf_lpf.sv
module ddsrf_lpf import ddsrf_pkg::*; #(
  parameter int DW = 16,
  parameter int GB = 8,
  parameter int KF = 506
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  wide_t                x,
  output logic signed [DW-1:0] y
);
  localparam int SW = DW + GB;
  localparam int FB = DW - 1;

  logic signed [SW-1:0] st_q, st_d;

  always_comb begin
    wide_t xs, nxt;
    xs   = clamp_s(x, DW) <<< GB;
    nxt  = wide_t'(st_q) + qmul(xs - wide_t'(st_q), wide_t'(KF), FB);
    st_d = SW'(clamp_s(nxt, SW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  st_q <= '0;
    else if (en) st_q <= st_d;
  end

  assign y = DW'(st_q >>> GB);
endmodule

// File: rtl/ddsrf_loop.sv
module ddsrf_loop import ddsrf_pkg::*; #(
  parameter int     PW   = 32,
  parameter longint NOM  = 21474836,
  parameter longint FMIN = 19327353,
  parameter longint FMAX = 23622319,
  parameter int     KP   = 192,
  parameter int     KI   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  wide_t         err,
  output logic [PW-1:0] freq,
  output logic [PW-1:0] theta
);
  logic [PW-1:0] integ_q, integ_d, freq_d, theta_d;

  function automatic wide_t fclamp(input wide_t v);
    if (v > wide_t'(FMAX)) return wide_t'(FMAX);
    else if (v < wide_t'(FMIN)) return wide_t'(FMIN);
    else return v;
  endfunction

  // Backward Euler: integrator and angle both use this sample's values
  always_comb begin
    wide_t ie, fe;
    ie      = fclamp(wide_t'(integ_q) + err * wide_t'(KI));
    fe      = fclamp(ie + err * wide_t'(KP));
    integ_d = PW'(ie);
    freq_d  = PW'(fe);
    theta_d = theta + freq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= PW'(NOM);
      freq    <= PW'(NOM);
      theta   <= '0;
    end else if (en) begin
      integ_q <= integ_d;
      freq    <= freq_d;
      theta   <= theta_d;
    end
  end
endmodule

// File: rtl/ddsrf_pll.sv
module ddsrf_pll import ddsrf_pkg::*; #(
  parameter int DW       = 16,
  parameter int PW       = 32,
  parameter int LB       = 6,
  parameter int GB       = 8,
  parameter int FS_HZ    = 10000,
  parameter int FNOM_HZ  = 50,
  parameter int SPAN_DIV = 10,
  parameter int KP       = 192,
  parameter int KI       = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_stb,
  input  logic signed [DW-1:0] ph_a,
  input  logic signed [DW-1:0] ph_b,
  input  logic signed [DW-1:0] ph_c,
  output logic                 out_vld,
  output logic [PW-1:0]        freq_inc,
  output logic [PW-1:0]        theta,
  output logic signed [DW-1:0] pos_d,
  output logic signed [DW-1:0] pos_q,
  output logic signed [DW-1:0] neg_d,
  output logic signed [DW-1:0] neg_q
);
  localparam int     FB       = DW - 1;
  localparam longint ONE_Q    = longint'(1) <<< FB;
  localparam longint NOM_INC  = ((longint'(1) <<< PW) * FNOM_HZ) / FS_HZ;
  localparam longint FMIN_INC = NOM_INC - NOM_INC / SPAN_DIV;
  localparam longint FMAX_INC = NOM_INC + NOM_INC / SPAN_DIV;
  localparam longint K_THIRD  = (ONE_Q + 1) / 3;
  localparam longint K_ISQ3   = (ONE_Q * 577350) / 1000000;
  // first-order cutoff at half nominal: a = pi*f/(fs + pi*f)
  localparam int     KF       = int'((longint'(3142) * FNOM_HZ * ONE_Q) /
                                     (longint'(1000) * FS_HZ + longint'(3142) * FNOM_HZ));

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s_n = rs_q[1];

  // trig of previous-sample angle and of twice that angle
  logic [PW-1:0]        theta2;
  logic signed [DW-1:0] s1, c1, s2, c2;
  assign theta2 = {theta[PW-2:0], 1'b0};

  ddsrf_trig #(.PW(PW), .DW(DW), .LB(LB)) u_trig1 (.phase(theta),  .sin_o(s1), .cos_o(c1));
  ddsrf_trig #(.PW(PW), .DW(DW), .LB(LB)) u_trig2 (.phase(theta2), .sin_o(s2), .cos_o(c2));

  logic signed [DW-1:0] flt [4];
  wide_t                dec [4];

  always_comb begin
    wide_t al, be, ws1, wc1, ws2, wc2, dp, qp, dn, qn;
    ws1 = wide_t'(s1); wc1 = wide_t'(c1);
    ws2 = wide_t'(s2); wc2 = wide_t'(c2);
    al  = qmul((wide_t'(ph_a) <<< 1) - wide_t'(ph_b) - wide_t'(ph_c), wide_t'(K_THIRD), FB);
    be  = qmul(wide_t'(ph_b) - wide_t'(ph_c), wide_t'(K_ISQ3), FB);
    // forward frame (+theta) and reverse frame (-theta)
    dp  = qmul(al, wc1, FB) + qmul(be, ws1, FB);
    qp  = qmul(be, wc1, FB) - qmul(al, ws1, FB);
    dn  = qmul(al, wc1, FB) - qmul(be, ws1, FB);
    qn  = qmul(al, ws1, FB) + qmul(be, wc1, FB);
    // remove the other sequence, rotated by 2*theta, using last filtered values
    dec[CH_DP] = dp - qmul(wide_t'(flt[CH_DN]), wc2, FB) - qmul(wide_t'(flt[CH_QN]), ws2, FB);
    dec[CH_QP] = qp + qmul(wide_t'(flt[CH_DN]), ws2, FB) - qmul(wide_t'(flt[CH_QN]), wc2, FB);
    dec[CH_DN] = dn - qmul(wide_t'(flt[CH_DP]), wc2, FB) + qmul(wide_t'(flt[CH_QP]), ws2, FB);
    dec[CH_QN] = qn - qmul(wide_t'(flt[CH_DP]), ws2, FB) - qmul(wide_t'(flt[CH_QP]), wc2, FB);
  end

  for (genvar i = 0; i < 4; i++) begin : g_lpf
    ddsrf_lpf #(.DW(DW), .GB(GB), .KF(KF)) u_lpf (
      .clk(clk), .rst_n(rst_s_n), .en(smp_stb), .x(dec[i]), .y(flt[i])
    );
  end

  ddsrf_loop #(
    .PW(PW), .NOM(NOM_INC), .FMIN(FMIN_INC), .FMAX(FMAX_INC), .KP(KP), .KI(KI)
  ) u_loop (
    .clk(clk), .rst_n(rst_s_n), .en(smp_stb), .err(clamp_s(dec[CH_QP], DW)),
    .freq(freq_inc), .theta(theta)
  );

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) out_vld <= 1'b0;
    else          out_vld <= smp_stb;
  end

  assign pos_d = flt[CH_DP];
  assign pos_q = flt[CH_QP];
  assign neg_d = flt[CH_DN];
  assign neg_q = flt[CH_QN];
endmodule

// File: rtl/ddsrf_pll_chk.sv
module ddsrf_pll_chk #(
  parameter int     PW   = 32,
  parameter int     DW   = 16,
  parameter longint NOM  = 21474836,
  parameter longint FMIN = 19327353,
  parameter longint FMAX = 23622319
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 smp_stb,
  input logic                 out_vld,
  input logic [PW-1:0]        freq_inc,
  input logic [PW-1:0]        theta,
  input logic signed [DW-1:0] pos_d,
  input logic signed [DW-1:0] neg_q
);
  // R1: on reset release the loop state holds its start values
  a_r1_start_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (longint'(freq_inc) == NOM && theta == '0));

  // R2: one valid pulse per strobe, one cycle later
  a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> out_vld);
  a_r2_vld_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> !out_vld);

  // R3: nothing moves without a strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_stb |=> ($stable(theta) && $stable(freq_inc) && $stable(pos_d) && $stable(neg_q)));

  // R5: angle steps by the freshly computed frequency
  a_r5_theta_step: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> theta == PW'($past(theta) + freq_inc));

  // R6: frequency estimate stays inside its window
  a_r6_freq_window: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(freq_inc) >= FMIN && longint'(freq_inc) <= FMAX);
endmodule

bind ddsrf_pll ddsrf_pll_chk #(
  .PW(PW), .DW(DW), .NOM(NOM_INC), .FMIN(FMIN_INC), .FMAX(FMAX_INC)
) u_chk (
  .clk(clk), .rst_n(rst_s_n), .smp_stb(smp_stb), .out_vld(out_vld),
  .freq_inc(freq_inc), .theta(theta), .pos_d(pos_d), .neg_q(neg_q)
);

// File: tb/ddsrf_pll_bench.sv
module ddsrf_pll_bench;
  localparam int     CLK_PERIOD = 10;
  localparam longint NOM  = 21474836;
  localparam longint FMIN = 19327353;
  localparam longint FMAX = 23622319;
  localparam int     NSMP = 5000;
  localparam real    TWO_PI = 6.283185307179586;
  // rows: input Hz, positive amplitude, negative amplitude (Q1.15)
  localparam int ROWS = 6;
  localparam int TBL [ROWS][3] = '{
    '{50, 16384, 0}, '{50, 16384, 6554}, '{52, 13107, 3277},
    '{48, 16384, 0}, '{60, 16384, 0},    '{40, 16384, 0}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0;
  logic signed [15:0] va = '0, vb = '0, vc = '0;
  logic        out_vld;
  logic [31:0] freq_inc, theta;
  logic signed [15:0] pos_d, pos_q, neg_d, neg_q;

  ddsrf_pll u_ddsrf_pll (
    .clk(clk), .rst_n(rst_n), .smp_stb(stb), .ph_a(va), .ph_b(vb), .ph_c(vc),
    .out_vld(out_vld), .freq_inc(freq_inc), .theta(theta),
    .pos_d(pos_d), .pos_q(pos_q), .neg_d(neg_d), .neg_q(neg_q));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_err = 0, vld_bad = 0;
  longint f_lo, f_hi;
  real ph = 0.0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic signed [15:0] q15(input real x);
    return 16'($rtoi(x >= 0.0 ? x + 0.5 : x - 0.5));
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; stb = 1'b0; va = '0; vb = '0; vc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    ph = 0.0; f_lo = NOM; f_hi = NOM;
  endtask

  // one strobe; called at a falling edge, returns at a falling edge
  task automatic sample(input real fhz, input real p, input real n);
    real sh;
    sh = TWO_PI / 3.0;
    va = q15(p * $cos(ph) + n * $cos(ph));
    vb = q15(p * $cos(ph - sh) + n * $cos(ph + sh));
    vc = q15(p * $cos(ph + sh) + n * $cos(ph - sh));
    stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    if (out_vld !== 1'b1) vld_bad++;
    if (longint'(freq_inc) < f_lo) f_lo = longint'(freq_inc);
    if (longint'(freq_inc) > f_hi) f_hi = longint'(freq_inc);
    @(negedge clk);
    if (out_vld !== 1'b0) vld_bad++;
    ph = ph + TWO_PI * fhz / 10000.0;
    if (ph > TWO_PI) ph = ph - TWO_PI;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    // R1: reset state, during and after reset
    repeat (2) @(negedge clk);
    chk(freq_inc == 32'(NOM) && theta == 0, "R1 loop during reset", longint'(freq_inc), NOM);
    do_reset();
    chk(freq_inc == 32'(NOM), "R1 freq after release", longint'(freq_inc), NOM);
    chk(theta == 0, "R1 theta after release", longint'(theta), 0);
    chk(pos_d == 0 && pos_q == 0 && neg_d == 0 && neg_q == 0, "R1 dq zero",
        longint'(pos_d) + longint'(neg_q), 0);
    chk(out_vld == 1'b0, "R1 out_vld low", longint'(out_vld), 0);

    // R4: zero input advances the angle by the nominal step only
    for (int i = 0; i < 7; i++) sample(50.0, 0.0, 0.0);
    chk(theta == 32'(7 * NOM), "R4 theta after 7 strobes", longint'(theta), (7 * NOM) % (longint'(1) <<< 32));
    chk(freq_inc == 32'(NOM), "R4 freq stays nominal", longint'(freq_inc), NOM);
    chk(pos_d == 0 && pos_q == 0 && neg_d == 0 && neg_q == 0, "R4 dq stay zero",
        longint'(pos_d) + longint'(neg_d), 0);
    chk(vld_bad == 0, "R2 single valid pulse per strobe", vld_bad, 0);

    // R7 R8 R9 R6: table of scenarios from a fresh reset each
    for (int r = 0; r < ROWS; r++) begin
      real fh, pa, na, nmag;
      longint fexp;
      fh = real'(TBL[r][0]); pa = real'(TBL[r][1]); na = real'(TBL[r][2]);
      do_reset();
      for (int s = 0; s < NSMP; s++) sample(fh, pa, na);
      nmag = $sqrt(real'(neg_d) * real'(neg_d) + real'(neg_q) * real'(neg_q));
      if (TBL[r][0] >= 45 && TBL[r][0] <= 55) begin
        fexp = longint'($rtoi(fh * 4294967296.0 / 10000.0));
        chk(longint'(pos_d) > longint'(TBL[r][1]) - 1500 && longint'(pos_d) < longint'(TBL[r][1]) + 1500,
            $sformatf("R7 R9 pos_d row %0d", r), longint'(pos_d), longint'(TBL[r][1]));
        chk(pos_q > -16'sd1500 && pos_q < 16'sd1500, $sformatf("R7 pos_q row %0d", r), longint'(pos_q), 0);
        chk(nmag > na - 1500.0 && nmag < na + 1500.0, $sformatf("R8 neg magnitude row %0d", r),
            longint'($rtoi(nmag)), longint'(TBL[r][2]));
        chk(longint'(freq_inc) > fexp - 214748 && longint'(freq_inc) < fexp + 214748,
            $sformatf("R9 freq row %0d", r), longint'(freq_inc), fexp);
      end else if (TBL[r][0] > 55) begin
        chk(f_hi == FMAX, "R6 reaches upper clamp", f_hi, FMAX);
        chk(f_lo >= FMIN, "R6 stays above lower clamp", f_lo, FMIN);
      end else begin
        chk(f_lo == FMIN, "R6 reaches lower clamp", f_lo, FMIN);
        chk(f_hi <= FMAX, "R6 stays below upper clamp", f_hi, FMAX);
      end
      if (r == 0) begin
        // R3: nonzero inputs without a strobe change nothing
        logic [31:0] th0, fr0;
        logic signed [15:0] pd0, nq0;
        th0 = theta; fr0 = freq_inc; pd0 = pos_d; nq0 = neg_q;
        va = 16'sd20000; vb = -16'sd9000; vc = 16'sd3000;
        repeat (5) @(negedge clk);
        chk(theta == th0 && freq_inc == fr0, "R3 loop holds without strobe", longint'(theta), longint'(th0));
        chk(pos_d == pd0 && neg_q == nq0, "R3 dq hold without strobe", longint'(pos_d), longint'(pd0));
        // R5: angle step equals the new frequency
        sample(50.0, 16384.0, 0.0);
        chk(theta == th0 + freq_inc, "R5 theta step", longint'(theta), longint'(32'(th0 + freq_inc)));
      end
    end
    chk(vld_bad == 0, "R2 valid pulse over all runs", vld_bad, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule